// File: doc/BRIEF.md
# Per-Warp Reduced Register Scoreboard

This block tracks, for every warp of a multithreaded core, which destination registers still have a write outstanding. A full bit per architectural register is not kept. Each warp has a small table of pending-write slots, and each buffered instruction carries a dependency vector with one bit per slot of its warp. At decode, the source and destination registers of the new instruction are compared with the warp's occupied slots. Every slot that matches sets its bit in the vector, which is then stored with the instruction.

An instruction is ready only when its vector is all zero. When a ready instruction issues, its destination claims the lowest free slot. Buffered instructions of the same warp that name that register then pick up the new bit. A writeback frees the slot holding the written register and clears that bit in every buffered instruction of the warp. An instruction that has a destination is held back while its warp's table is full. The register file and the choice of which ready instruction issues are outside this block.

Top module: `sb_scoreboard`

## Requirements
- R1: During and right after reset, no entry is ready, every dependency vector is zero and no warp's table is full.
- R2: On decode, the stored vector has bit s set when slot s of that warp is occupied by a register equal to a nonzero source operand (read-after-write).
- R3: On decode, bit s is also set when slot s holds a register equal to the nonzero destination (write-after-write).
- R4: Register index 0 means "no operand": it never matches a slot, and an instruction whose destination is 0 claims no slot when it issues.
- R5: `ready_mask` bit (warp*ENTRIES+entry) is 1 only for an occupied entry whose dependency vector is zero. If its destination is nonzero, the warp's table must also not be full.
- R6: An issue request on a ready entry raises `iss_taken` in the same cycle and frees the entry. A nonzero destination claims the lowest-numbered free slot. A request on an entry that is not ready changes nothing.
- R7: With all SLOTS slots of a warp in use, `table_full` for that warp is 1, and a buffered entry with a nonzero destination is not ready.
- R8: A writeback of a nonzero register to a warp frees the slot holding that register and clears its bit in every entry of that warp only. Other warps are unaffected.
- R9: When a writeback and a decode of the same warp fall in one cycle, the writeback is applied first, so the decoded instruction does not depend on the freed slot.
- R10: When an instruction issues, every other buffered entry of the same warp naming its destination gains the bit of the newly claimed slot. A decode in the same cycle sees the new slot too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decoded instruction is written into a buffer entry |
| dec_warp | input | WW | Warp of the decoded instruction |
| dec_entry | input | EW | Buffer entry within the warp |
| dec_src0 | input | RW | First source register, 0 = none |
| dec_src1 | input | RW | Second source register, 0 = none |
| dec_dst | input | RW | Destination register, 0 = none |
| iss_valid | input | 1 | Issue request |
| iss_warp | input | WW | Warp of the issue request |
| iss_entry | input | EW | Entry of the issue request |
| wb_valid | input | 1 | Result writeback |
| wb_warp | input | WW | Warp of the writeback |
| wb_reg | input | RW | Register written back |
| iss_taken | output | 1 | Issue request accepted this cycle |
| ready_mask | output | WARPS*ENTRIES | Per-entry ready flag, index warp*ENTRIES+entry |
| dep_flat | output | WARPS*ENTRIES*SLOTS | Dependency vectors, entry i at bits [i*SLOTS +: SLOTS] |
| table_full | output | WARPS | All slots of the warp are in use |

## Verification
A wrong slot in a warp's table shows up as a wrong dependency vector in `dep_flat`. It appears on the edge after the next decode or issue of that warp that names the register, or as a missing clear after its writeback. A wrong vector or a miscounted table shows at once in `ready_mask`, and through it in `iss_taken`, in the following cycle. The bench therefore compares every output against a behavioural model on every clock. That catches a fault within one cycle of the stimulus that exposes it, and directed sequences force the same-cycle clear, allocate and full cases.

// File: rtl/sb_pkg.sv
// Package: default sizes of the reduced scoreboard.
// Assumes register index 0 is reserved to mean "no operand".
package sb_pkg;
    localparam int SB_WARPS   = 4;   // warps tracked
    localparam int SB_ENTRIES = 2;   // buffered instructions per warp
    localparam int SB_SLOTS   = 6;   // pending-write slots per warp
    localparam int SB_REGW    = 7;   // register index width (128 registers)
endpackage

// File: rtl/sb_match.sv
// Module: compares one register index against every occupied slot of a table.
// Assumes a key of 0 means "no operand" and never matches.
module sb_match #(
    parameter int SLOTS = 6,
    parameter int RW    = 7
) (
    input  logic [SLOTS-1:0]         slot_vld,
    input  logic [SLOTS-1:0][RW-1:0] slot_reg,
    input  logic [RW-1:0]            key,
    output logic [SLOTS-1:0]         hit
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
        // Per-slot equality against a nonzero key.
        assign hit[s] = slot_vld[s] && (key != '0) && (slot_reg[s] == key);
    end
endmodule

// File: rtl/sb_warp_table.sv
// Module: pending-write slot table of one warp.
// A writeback clears the slot holding its register, then an issue claims the
// lowest free slot. The table state after both steps is exported so that a
// decode in the same cycle sees it. Assumes a register occupies at most one slot.
module sb_warp_table #(
    parameter int SLOTS = 6,
    parameter int RW    = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_en,
    input  logic [RW-1:0]            clr_reg,
    input  logic                     alloc_en,
    input  logic [RW-1:0]            alloc_reg,
    output logic [SLOTS-1:0]         clr_mask,
    output logic [SLOTS-1:0]         alloc_mask,
    output logic [SLOTS-1:0]         vld_nx,
    output logic [SLOTS-1:0][RW-1:0] reg_nx,
    output logic                     full
);
    logic [SLOTS-1:0]         vld_q;
    logic [SLOTS-1:0][RW-1:0] reg_q;
    logic [SLOTS-1:0]         vld_cl;
    logic [SLOTS-1:0]         pick;
    logic                     found;

    // Slots released by a writeback of this warp.
    sb_match #(.SLOTS(SLOTS), .RW(RW)) u_clr (
        .slot_vld (clr_en ? vld_q : '0),
        .slot_reg (reg_q),
        .key      (clr_reg),
        .hit      (clr_mask)
    );

    // Lowest free slot after the clear.
    always_comb begin
        vld_cl = vld_q & ~clr_mask;
        pick   = '0;
        found  = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (!vld_cl[s] && !found) begin
                pick[s] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    // Next table contents: clear first, then allocate.
    always_comb begin
        alloc_mask = (alloc_en && (alloc_reg != '0)) ? pick : '0;
        vld_nx     = vld_cl | alloc_mask;
        for (int s = 0; s < SLOTS; s++) begin
            reg_nx[s] = alloc_mask[s] ? alloc_reg : reg_q[s];
        end
    end

    // Full flag from the registered table.
    assign full = &vld_q;

    // Table state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            reg_q <= '0;
        end else begin
            vld_q <= vld_nx;
            reg_q <= reg_nx;
        end
    end
endmodule

// File: rtl/sb_ibuf_entry.sv
// Module: scoreboard state of one buffered instruction: its operands and its
// dependency vector. The vector loses bits on writeback and gains the newly
// claimed slot's bit when a same-warp issue writes a register it names.
// Assumes a load and a retire in the same cycle resolve to the load.
module sb_ibuf_entry #(
    parameter int SLOTS = 6,
    parameter int RW    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [RW-1:0]    load_src0,
    input  logic [RW-1:0]    load_src1,
    input  logic [RW-1:0]    load_dst,
    input  logic [SLOTS-1:0] load_dep,
    input  logic             retire_en,
    input  logic [SLOTS-1:0] clr_mask,
    input  logic [SLOTS-1:0] alloc_mask,
    input  logic [RW-1:0]    alloc_reg,
    output logic             vld,
    output logic [RW-1:0]    dst,
    output logic [SLOTS-1:0] dep
);
    logic [RW-1:0] src0_q, src1_q;
    logic          names_alloc;

    // Does this instruction read or write the register just allocated?
    assign names_alloc = (alloc_reg != '0) &&
                         ((src0_q == alloc_reg) || (src1_q == alloc_reg) || (dst == alloc_reg));

    // Entry state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld    <= 1'b0;
            src0_q <= '0;
            src1_q <= '0;
            dst    <= '0;
            dep    <= '0;
        end else if (load_en) begin
            vld    <= 1'b1;
            src0_q <= load_src0;
            src1_q <= load_src1;
            dst    <= load_dst;
            dep    <= load_dep;
        end else if (retire_en) begin
            vld    <= 1'b0;
            src0_q <= '0;
            src1_q <= '0;
            dst    <= '0;
            dep    <= '0;
        end else begin
            dep <= (dep & ~clr_mask) | (names_alloc ? alloc_mask : '0);
        end
    end
endmodule

// File: rtl/sb_scoreboard.sv
// Module: top of the per-warp reduced scoreboard. It holds one slot table per
// warp and one entry per buffered instruction, does the decode lookup against
// the post-writeback, post-allocate table, and forms the ready flags.
// Assumes WARPS and ENTRIES are at least 2 and that the issue scheduler picks
// among ready entries.
module sb_scoreboard
    import sb_pkg::*;
#(
    parameter  int WARPS   = SB_WARPS,
    parameter  int ENTRIES = SB_ENTRIES,
    parameter  int SLOTS   = SB_SLOTS,
    parameter  int RW      = SB_REGW,
    localparam int WW      = $clog2(WARPS),
    localparam int EW      = $clog2(ENTRIES),
    localparam int NENT    = WARPS * ENTRIES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dec_valid,
    input  logic [WW-1:0]         dec_warp,
    input  logic [EW-1:0]         dec_entry,
    input  logic [RW-1:0]         dec_src0,
    input  logic [RW-1:0]         dec_src1,
    input  logic [RW-1:0]         dec_dst,
    input  logic                  iss_valid,
    input  logic [WW-1:0]         iss_warp,
    input  logic [EW-1:0]         iss_entry,
    input  logic                  wb_valid,
    input  logic [WW-1:0]         wb_warp,
    input  logic [RW-1:0]         wb_reg,
    output logic                  iss_taken,
    output logic [NENT-1:0]       ready_mask,
    output logic [NENT*SLOTS-1:0] dep_flat,
    output logic [WARPS-1:0]      table_full
);
    logic [SLOTS-1:0]         tab_clr   [WARPS];
    logic [SLOTS-1:0]         tab_alloc [WARPS];
    logic [SLOTS-1:0]         tab_vld   [WARPS];
    logic [SLOTS-1:0][RW-1:0] tab_reg   [WARPS];

    logic             ent_vld [NENT];
    logic [RW-1:0]    ent_dst [NENT];
    logic [SLOTS-1:0] ent_dep [NENT];

    logic [SLOTS-1:0]         look_vld;
    logic [SLOTS-1:0][RW-1:0] look_reg;
    logic [SLOTS-1:0]         hit_s0, hit_s1, hit_d;
    logic [SLOTS-1:0]         dec_dep;
    logic                     sel_ready;
    logic [RW-1:0]            iss_dst;

    // Ready flag and destination of the entry named by the issue request.
    always_comb begin
        sel_ready = 1'b0;
        iss_dst   = '0;
        for (int w = 0; w < WARPS; w++) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (iss_warp == WW'(w) && iss_entry == EW'(e)) begin
                    sel_ready = ready_mask[w*ENTRIES+e];
                    iss_dst   = ent_dst[w*ENTRIES+e];
                end
            end
        end
    end

    assign iss_taken = iss_valid && sel_ready;

    // One slot table per warp.
    for (genvar w = 0; w < WARPS; w++) begin : g_warp
        sb_warp_table #(.SLOTS(SLOTS), .RW(RW)) u_tab (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr_en     (wb_valid && (wb_warp == WW'(w))),
            .clr_reg    (wb_reg),
            .alloc_en   (iss_taken && (iss_warp == WW'(w))),
            .alloc_reg  (iss_dst),
            .clr_mask   (tab_clr[w]),
            .alloc_mask (tab_alloc[w]),
            .vld_nx     (tab_vld[w]),
            .reg_nx     (tab_reg[w]),
            .full       (table_full[w])
        );
    end

    // Decode lookup selects the decoding warp's next-state table.
    always_comb begin
        look_vld = '0;
        look_reg = '0;
        for (int w = 0; w < WARPS; w++) begin
            if (dec_warp == WW'(w)) begin
                look_vld = tab_vld[w];
                look_reg = tab_reg[w];
            end
        end
    end

    sb_match #(.SLOTS(SLOTS), .RW(RW)) u_m_s0 (
        .slot_vld (look_vld), .slot_reg (look_reg), .key (dec_src0), .hit (hit_s0));
    sb_match #(.SLOTS(SLOTS), .RW(RW)) u_m_s1 (
        .slot_vld (look_vld), .slot_reg (look_reg), .key (dec_src1), .hit (hit_s1));
    sb_match #(.SLOTS(SLOTS), .RW(RW)) u_m_d (
        .slot_vld (look_vld), .slot_reg (look_reg), .key (dec_dst), .hit (hit_d));

    assign dec_dep = hit_s0 | hit_s1 | hit_d;

    // Buffered instruction entries, flat index warp*ENTRIES+entry.
    for (genvar w = 0; w < WARPS; w++) begin : g_w
        for (genvar e = 0; e < ENTRIES; e++) begin : g_e
            localparam int I = w * ENTRIES + e;

            sb_ibuf_entry #(.SLOTS(SLOTS), .RW(RW)) u_ent (
                .clk        (clk),
                .rst_n      (rst_n),
                .load_en    (dec_valid && (dec_warp == WW'(w)) && (dec_entry == EW'(e))),
                .load_src0  (dec_src0),
                .load_src1  (dec_src1),
                .load_dst   (dec_dst),
                .load_dep   (dec_dep),
                .retire_en  (iss_taken && (iss_warp == WW'(w)) && (iss_entry == EW'(e))),
                .clr_mask   (tab_clr[w]),
                .alloc_mask (tab_alloc[w]),
                .alloc_reg  (iss_dst),
                .vld        (ent_vld[I]),
                .dst        (ent_dst[I]),
                .dep        (ent_dep[I])
            );

            // Ready: occupied, no dependency, and a slot free if one is needed.
            assign ready_mask[I] = ent_vld[I] && (ent_dep[I] == '0) &&
                                   ((ent_dst[I] == '0) || !table_full[w]);
            assign dep_flat[I*SLOTS +: SLOTS] = ent_dep[I];
        end
    end
endmodule

// File: rtl/sb_scoreboard_chk.sv
// Module: assertion checker for the reduced scoreboard, bound to the top.
// Assumes the same parameter values as the instance it is bound to.
module sb_scoreboard_chk #(
    parameter int WARPS   = 4,
    parameter int ENTRIES = 2,
    parameter int SLOTS   = 6,
    parameter int WW      = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          dec_valid,
    input logic                          iss_valid,
    input logic                          iss_taken,
    input logic                          wb_valid,
    input logic [WW-1:0]                 wb_warp,
    input logic [WARPS*ENTRIES-1:0]      ready_mask,
    input logic [WARPS*ENTRIES*SLOTS-1:0] dep_flat,
    input logic [WARPS-1:0]              table_full
);
    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (ready_mask == '0 && table_full == '0 && dep_flat == '0)); // R1

    AST_DEP_ONLY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_valid && !iss_taken) |=> ((dep_flat & ~$past(dep_flat)) == '0)); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_valid && !iss_valid && !wb_valid) |=> ($stable(ready_mask) && $stable(dep_flat))); // R5

    for (genvar i = 0; i < WARPS*ENTRIES; i++) begin : g_ent
        AST_READY_NO_DEP: assert property (@(posedge clk) disable iff (!rst_n)
            ready_mask[i] |-> (dep_flat[i*SLOTS +: SLOTS] == '0)); // R5
    end

    for (genvar w = 0; w < WARPS; w++) begin : g_warp
        AST_FULL_UNTIL_WB: assert property (@(posedge clk) disable iff (!rst_n)
            (table_full[w] && !(wb_valid && wb_warp == WW'(w))) |=> table_full[w]); // R7
    end
endmodule

bind sb_scoreboard sb_scoreboard_chk #(
    .WARPS(WARPS), .ENTRIES(ENTRIES), .SLOTS(SLOTS), .WW(WW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .iss_valid(iss_valid),
    .iss_taken(iss_taken), .wb_valid(wb_valid), .wb_warp(wb_warp),
    .ready_mask(ready_mask), .dep_flat(dep_flat), .table_full(table_full)
);

// File: tb/sb_scoreboard_bench.sv
module sb_scoreboard_bench;
    localparam int W = 4, E = 2, S = 6, RW = 7, WW = 2, EW = 1, N = W*E;

    logic clk = 0, rst_n = 0;
    logic dec_valid = 0, iss_valid = 0, wb_valid = 0;
    logic [WW-1:0] dec_warp = 0, iss_warp = 0, wb_warp = 0;
    logic [EW-1:0] dec_entry = 0, iss_entry = 0;
    logic [RW-1:0] dec_src0 = 0, dec_src1 = 0, dec_dst = 0, wb_reg = 0;
    logic iss_taken;
    logic [N-1:0] ready_mask;
    logic [N*S-1:0] dep_flat;
    logic [W-1:0] table_full;

    int total = 0, bad = 0;
    bit finished = 0;

    // Behavioural model state.
    int tv [W][S];  int tr [W][S];
    int ev [W][E];  int es0 [W][E]; int es1 [W][E]; int ed [W][E]; int edep [W][E];

    always #2 clk = ~clk;

    sb_scoreboard u_sb_scoreboard (.*);

    task automatic chk(string req, longint got, longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
        end
    endtask

    function automatic bit m_full(int w);
        for (int s = 0; s < S; s++) if (tv[w][s] == 0) return 0;
        return 1;
    endfunction

    function automatic bit m_ready(int w, int e);
        return ev[w][e] != 0 && edep[w][e] == 0 && (ed[w][e] == 0 || !m_full(w));
    endfunction

    task automatic model_reset();
        for (int w = 0; w < W; w++) begin
            for (int s = 0; s < S; s++) begin tv[w][s] = 0; tr[w][s] = 0; end
            for (int e = 0; e < E; e++) begin
                ev[w][e] = 0; es0[w][e] = 0; es1[w][e] = 0; ed[w][e] = 0; edep[w][e] = 0;
            end
        end
    endtask

    // Compare all outputs with the model (before the coming edge).
    task automatic chk_all();
        logic [N-1:0] xr; logic [N*S-1:0] xd; logic [W-1:0] xf; bit xt;
        for (int w = 0; w < W; w++) begin
            xf[w] = m_full(w);
            for (int e = 0; e < E; e++) begin
                xr[w*E+e] = m_ready(w, e);
                xd[(w*E+e)*S +: S] = S'(edep[w][e]);
            end
        end
        xt = iss_valid && m_ready(int'(iss_warp), int'(iss_entry));
        chk("R5 ready_mask", ready_mask, xr);
        chk("R2 dep_flat", dep_flat, xd);
        chk("R7 table_full", table_full, xf);
        chk("R6 iss_taken", iss_taken, xt);
    endtask

    // Advance the model by one edge using the driven inputs.
    task automatic model_step();
        int clr [W]; int amask; int adst; bit take; int iw, ie;
        iw = int'(iss_warp); ie = int'(iss_entry);
        take = iss_valid && m_ready(iw, ie);
        adst = take ? ed[iw][ie] : 0;
        amask = 0;
        for (int w = 0; w < W; w++) begin
            clr[w] = 0;
            if (wb_valid && int'(wb_warp) == w && wb_reg != 0)
                for (int s = 0; s < S; s++)
                    if (tv[w][s] != 0 && tr[w][s] == int'(wb_reg)) clr[w] |= (1 << s);
            for (int s = 0; s < S; s++) if (clr[w][s]) tv[w][s] = 0;
        end
        if (take && adst != 0) begin
            for (int s = 0; s < S; s++)
                if (amask == 0 && tv[iw][s] == 0) begin
                    tv[iw][s] = 1; tr[iw][s] = adst; amask = 1 << s;
                end
        end
        for (int w = 0; w < W; w++)
            for (int e = 0; e < E; e++) begin
                if (dec_valid && int'(dec_warp) == w && int'(dec_entry) == e) begin
                    int d = 0;
                    for (int s = 0; s < S; s++)
                        if (tv[w][s] != 0 &&
                            ((dec_src0 != 0 && tr[w][s] == int'(dec_src0)) ||
                             (dec_src1 != 0 && tr[w][s] == int'(dec_src1)) ||
                             (dec_dst  != 0 && tr[w][s] == int'(dec_dst)))) d |= (1 << s);
                    ev[w][e] = 1; es0[w][e] = int'(dec_src0); es1[w][e] = int'(dec_src1);
                    ed[w][e] = int'(dec_dst); edep[w][e] = d;
                end else if (take && w == iw && e == ie) begin
                    ev[w][e] = 0; es0[w][e] = 0; es1[w][e] = 0; ed[w][e] = 0; edep[w][e] = 0;
                end else begin
                    edep[w][e] &= ~clr[w];
                    if (take && w == iw && adst != 0 &&
                        (es0[w][e] == adst || es1[w][e] == adst || ed[w][e] == adst))
                        edep[w][e] |= amask;
                end
            end
    endtask

    task automatic idle();
        dec_valid = 0; iss_valid = 0; wb_valid = 0;
    endtask

    task automatic set_dec(int w, int e, int s0, int s1, int d);
        dec_valid = 1; dec_warp = WW'(w); dec_entry = EW'(e);
        dec_src0 = RW'(s0); dec_src1 = RW'(s1); dec_dst = RW'(d);
    endtask

    task automatic set_iss(int w, int e);
        iss_valid = 1; iss_warp = WW'(w); iss_entry = EW'(e);
    endtask

    task automatic set_wb(int w, int r);
        wb_valid = 1; wb_warp = WW'(w); wb_reg = RW'(r);
    endtask

    // One clock: check, edge, model update, back to the falling edge idle.
    task automatic tick();
        #1 chk_all();
        @(posedge clk);
        model_step();
        @(negedge clk);
        idle();
    endtask

    initial begin
        #100000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1 ready after reset", ready_mask, 0);
        chk("R1 dep after reset", dep_flat, 0);
        chk("R1 full after reset", table_full, 0);
        rst_n = 1;
        tick();

        // Warp 0 directed sequence.
        set_dec(0, 0, 1, 2, 5); tick();
        chk("R5 clean entry ready", ready_mask[0], 1);
        set_iss(0, 0); set_dec(0, 1, 5, 0, 6); tick();
        chk("R10 same-cycle decode sees new slot", dep_flat[1*S +: S], 6'b000001);
        chk("R2 RAW entry not ready", ready_mask[1], 0);
        chk("R6 issued entry freed", ready_mask[0], 0);
        set_dec(0, 0, 3, 4, 5); tick();
        chk("R3 WAW bit set", dep_flat[0 +: S], 6'b000001);
        set_wb(0, 5); tick();
        chk("R8 wb clears both entries", dep_flat[0 +: 2*S], 0);
        chk("R8 both ready", ready_mask[1:0], 2'b11);
        set_iss(0, 1); tick();
        set_dec(0, 1, 6, 0, 0); set_wb(0, 6); tick();
        chk("R9 clear before lookup", dep_flat[1*S +: S], 0);
        chk("R9 entry ready", ready_mask[1], 1);

        // Warp 2: fill all slots.
        for (int k = 1; k <= S; k++) begin
            set_dec(2, 0, 0, 0, 10 + k); tick();
            set_iss(2, 0); tick();
        end
        chk("R7 warp full", table_full, 4'b0100);
        set_dec(2, 0, 0, 0, 20); tick();
        set_dec(2, 1, 0, 0, 0); tick();
        chk("R7 dst entry blocked when full", ready_mask[4], 0);
        chk("R4 no-dst entry ready when full", ready_mask[5], 1);
        set_iss(2, 0); #1 chk("R6 blocked issue ignored", iss_taken, 0); tick();
        chk("R6 blocked entry kept", ready_mask[4], 0);
        set_iss(2, 1); tick();
        chk("R4 no slot claimed for dst 0", table_full[2], 1);
        set_wb(2, 11); tick();
        chk("R8 wb frees slot", table_full[2], 0);
        chk("R8 entry ready after wb", ready_mask[4], 1);
        chk("R8 other warps untouched", dep_flat[0 +: 4*S], 0);

        // Mixed random traffic with small register range to force hits.
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 1) == 1)
                set_dec($urandom_range(0, W-1), $urandom_range(0, E-1),
                        $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
            if ($urandom_range(0, 2) != 0)
                set_iss($urandom_range(0, W-1), $urandom_range(0, E-1));
            if ($urandom_range(0, 2) == 0)
                set_wb($urandom_range(0, W-1), $urandom_range(0, 7));
            tick();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule